// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry for a 32-bit core. Each request arrives as a single-cycle pulse. It carries a kind, a cause code, the faulting PC and, where relevant, a faulting virtual address. On the next clock edge the block updates the architectural state it owns: the status word, the exception and double-exception return PCs, the cause and fault-address registers, and the debug cause, debug return PC and saved status. In the same edge it raises a one-cycle redirect strobe that carries a vector identifier.

A separate debug channel enters debug state only when the current interrupt level is below a compile-time debug level. The core can also load the status word directly, for example on return from a handler. Vector address tables, fetch and pipeline flushing belong to the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the status word equals RESET_PS (default 0x1F) and every other register output is zero. The redirect strobe is low and the vector ID is 0 (none).
- R2: The status word holds the interrupt level in bits 3:0, the exception-mode flag (EXCM) in bit 4 and the user-mode flag in bit 5. When a general exception is taken with EXCM clear, the PC is written to the exception PC. The vector ID is 2 (user) if the user-mode flag is set and 1 (kernel) otherwise.
- R3: When a general exception is taken with EXCM set, the vector ID is 3 (double). With HAS_DEPC=1 (the default) the PC goes to the double-exception PC and the exception PC is left unchanged. With HAS_DEPC=0 the PC goes to the exception PC.
- R4: Every general exception taken writes its cause into the cause register and sets EXCM. All other status bits are unchanged.
- R5: The request kind is a 2-bit code: 0 = plain, 1 = address fault, 2 = misaligned, 3 = bus error. An address fault loads the fault-address register with the request's virtual address. A plain request leaves that register unchanged.
- R6: With the unaligned-exception option on and hardware alignment off (the default), a misaligned request writes cause CAUSE_ALIGN (9) and loads the fault address. In any other configuration the request is ignored: no redirect and no register change.
- R7: A bus-error request with the fetch flag set writes cause CAUSE_FETCH_ERR (12) and reports the PC as the fault address. With the fetch flag clear it writes CAUSE_DATA_ERR (13) and reports the virtual address.
- R8: A debug request with interrupt level below DEBUG_LEVEL (default 6) does all of the following:
  - writes the debug cause and the debug return PC;
  - copies the old status word into the saved-status register;
  - sets the interrupt level to DEBUG_LEVEL and sets EXCM;
  - gives vector ID 4.
  The exception PC and the cause register are not touched.
- R9: A debug request with interrupt level at or above DEBUG_LEVEL is ignored.
- R10: When an accepted debug request and a general request arrive in the same cycle, only the debug entry happens. When the debug request is refused, the general request is taken.
- R11: Redirect is high for exactly the one cycle after a taken request. The vector ID is 0 whenever redirect is low.
- R12: A status load writes the status word only in a cycle in which no exception is taken. Otherwise the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | General exception request pulse |
| req_kind | input | 2 | Request kind (R5 encoding) |
| req_cause | input | 6 | Cause code for plain and address-fault kinds |
| req_pc | input | 32 | Faulting PC |
| req_vaddr | input | 32 | Faulting data virtual address |
| req_is_fetch | input | 1 | Bus error came from instruction fetch |
| dbg_valid | input | 1 | Debug exception request pulse |
| dbg_cause | input | 6 | Debug cause code |
| dbg_pc | input | 32 | PC for debug entry |
| ps_wr_en | input | 1 | Direct status-word load |
| ps_wr_data | input | 8 | Status value to load |
| ps | output | 8 | Status word |
| epc | output | 32 | Exception return PC |
| depc | output | 32 | Double-exception return PC |
| exccause | output | 6 | Exception cause |
| excvaddr | output | 32 | Faulting virtual address |
| dbgcause | output | 6 | Debug cause |
| dbg_epc | output | 32 | Debug-level return PC |
| dbg_eps | output | 8 | Status saved at debug entry |
| redirect | output | 1 | One-cycle redirect strobe |
| vector_id | output | 3 | Selected vector (0 none, 1 kernel, 2 user, 3 double, 4 debug) |

## Verification
A debug request and a general request can land in the same cycle. A status load can also coincide with either kind of entry. The bench sweeps every interrupt level with both request pulses raised together. At levels below the debug threshold, the debug channel alone must change state: the cause register and exception PC must keep their earlier values. At or above the threshold, the general request must go through as if alone. Status loads raised together with an entry are judged by whether the status word reflects the entry rather than the loaded value.

// File: rtl/exc_entry_pkg.sv
// Shared constants and encodings for the exception entry controller.
// Assumes an 8-bit status word; only the fields listed here have meaning.
package exc_entry_pkg;
    localparam int PS_W         = 8;
    localparam int PS_LVL_LSB   = 0;
    localparam int PS_LVL_W     = 4;
    localparam int PS_EXCM_BIT  = 4;
    localparam int PS_UM_BIT    = 5;

    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    typedef enum logic [1:0] {
        KIND_PLAIN    = 2'd0,
        KIND_ADDR     = 2'd1,
        KIND_MISALIGN = 2'd2,
        KIND_BUSERR   = 2'd3
    } kind_e;
endpackage

// File: rtl/exc_fault_classify.sv
// Turns a general request into a final cause code, an accept flag and the
// fault address to record. Purely combinational; assumes the kind encoding
// of exc_entry_pkg. Alignment faults are accepted only in the configuration
// chosen by UNALIGNED_EXC and HW_ALIGN.
module exc_fault_classify
    import exc_entry_pkg::*;
#(
    parameter int XLEN            = 32,
    parameter int CAUSE_W         = 6,
    parameter bit UNALIGNED_EXC   = 1'b1,
    parameter bit HW_ALIGN        = 1'b0,
    parameter int CAUSE_ALIGN     = 9,
    parameter int CAUSE_FETCH_ERR = 12,
    parameter int CAUSE_DATA_ERR  = 13
) (
    input  logic [1:0]         kind,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    vaddr,
    input  logic               is_fetch,
    output logic               accept,
    output logic [CAUSE_W-1:0] cause_out,
    output logic               load_va,
    output logic [XLEN-1:0]    va_out
);
    logic align_enabled;

    // Pick whether misaligned accesses trap in this configuration.
    generate
        if (UNALIGNED_EXC && !HW_ALIGN) begin : g_align_trap
            assign align_enabled = 1'b1;
        end else begin : g_align_quiet
            assign align_enabled = 1'b0;
        end
    endgenerate

    // Decode kind into cause, acceptance and address source.
    always_comb begin
        accept    = 1'b1;
        cause_out = cause_in;
        load_va   = 1'b0;
        va_out    = vaddr;
        unique case (kind_e'(kind))
            KIND_PLAIN: begin
                load_va = 1'b0;
            end
            KIND_ADDR: begin
                load_va = 1'b1;
            end
            KIND_MISALIGN: begin
                accept    = align_enabled;
                cause_out = CAUSE_W'(CAUSE_ALIGN);
                load_va   = 1'b1;
            end
            KIND_BUSERR: begin
                load_va   = 1'b1;
                cause_out = is_fetch ? CAUSE_W'(CAUSE_FETCH_ERR) : CAUSE_W'(CAUSE_DATA_ERR);
                va_out    = is_fetch ? pc : vaddr;
            end
            default: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_route.sv
// Chooses the vector and the return-PC register for a general exception
// from the current mode flags. Combinational; assumes a taken request.
module exc_route
    import exc_entry_pkg::*;
#(
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic       excm,
    input  logic       um,
    output logic [2:0] vec,
    output logic       to_epc,
    output logic       to_depc
);
    // Vector selection by nesting and privilege.
    always_comb begin
        if (excm)    vec = VEC_DOUBLE;
        else if (um) vec = VEC_USER;
        else         vec = VEC_KERNEL;
    end

    // Return-PC destination depends on whether a double-exception PC exists.
    generate
        if (HAS_DEPC) begin : g_depc
            assign to_depc = excm;
            assign to_epc  = !excm;
        end else begin : g_no_depc
            assign to_depc = 1'b0;
            assign to_epc  = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/exc_debug_gate.sv
// Decides whether a debug request is accepted at the current interrupt
// level and forms the status word that debug entry installs.
// Assumes 2 <= DEBUG_LEVEL <= 6.
module exc_debug_gate
    import exc_entry_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6
) (
    input  logic            dbg_valid,
    input  logic [PS_W-1:0] ps_cur,
    output logic            take,
    output logic [PS_W-1:0] ps_dbg
);
    localparam logic [PS_LVL_W-1:0] LVL = PS_LVL_W'(DEBUG_LEVEL);

    // Accept only below the debug level.
    assign take = dbg_valid && (ps_cur[PS_LVL_LSB +: PS_LVL_W] < LVL);

    // Raise level to the debug level and enter exception mode.
    always_comb begin
        ps_dbg = ps_cur;
        ps_dbg[PS_LVL_LSB +: PS_LVL_W] = LVL;
        ps_dbg[PS_EXCM_BIT] = 1'b1;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller: owns the status word and the exception
// bookkeeping registers, and on a taken request updates them and pulses
// redirect with a vector ID on the same clock edge.
// Priority: accepted debug > general request > direct status load.
// Assumes request pulses last a single cycle; synchronous active-low reset.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN            = 32,
    parameter int              CAUSE_W         = 6,
    parameter int              DBG_CAUSE_W     = 6,
    parameter bit              HAS_DEPC        = 1'b1,
    parameter bit              UNALIGNED_EXC   = 1'b1,
    parameter bit              HW_ALIGN        = 1'b0,
    parameter int              DEBUG_LEVEL     = 6,
    parameter logic [PS_W-1:0] RESET_PS        = 8'h1F,
    parameter int              CAUSE_ALIGN     = 9,
    parameter int              CAUSE_FETCH_ERR = 12,
    parameter int              CAUSE_DATA_ERR  = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_kind,
    input  logic [CAUSE_W-1:0]     req_cause,
    input  logic [XLEN-1:0]        req_pc,
    input  logic [XLEN-1:0]        req_vaddr,
    input  logic                   req_is_fetch,
    input  logic                   dbg_valid,
    input  logic [DBG_CAUSE_W-1:0] dbg_cause,
    input  logic [XLEN-1:0]        dbg_pc,
    input  logic                   ps_wr_en,
    input  logic [PS_W-1:0]        ps_wr_data,
    output logic [PS_W-1:0]        ps,
    output logic [XLEN-1:0]        epc,
    output logic [XLEN-1:0]        depc,
    output logic [CAUSE_W-1:0]     exccause,
    output logic [XLEN-1:0]        excvaddr,
    output logic [DBG_CAUSE_W-1:0] dbgcause,
    output logic [XLEN-1:0]        dbg_epc,
    output logic [PS_W-1:0]        dbg_eps,
    output logic                   redirect,
    output logic [2:0]             vector_id
);
    logic               cls_accept;
    logic [CAUSE_W-1:0] cls_cause;
    logic               cls_load_va;
    logic [XLEN-1:0]    cls_va;
    logic [2:0]         rt_vec;
    logic               rt_to_epc;
    logic               rt_to_depc;
    logic               dbg_take;
    logic [PS_W-1:0]    ps_dbg;
    logic               gen_take;

    exc_fault_classify #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W),
        .UNALIGNED_EXC(UNALIGNED_EXC), .HW_ALIGN(HW_ALIGN),
        .CAUSE_ALIGN(CAUSE_ALIGN), .CAUSE_FETCH_ERR(CAUSE_FETCH_ERR),
        .CAUSE_DATA_ERR(CAUSE_DATA_ERR)
    ) u_classify (
        .kind(req_kind), .cause_in(req_cause), .pc(req_pc), .vaddr(req_vaddr),
        .is_fetch(req_is_fetch), .accept(cls_accept), .cause_out(cls_cause),
        .load_va(cls_load_va), .va_out(cls_va)
    );

    exc_route #(.HAS_DEPC(HAS_DEPC)) u_route (
        .excm(ps[PS_EXCM_BIT]), .um(ps[PS_UM_BIT]),
        .vec(rt_vec), .to_epc(rt_to_epc), .to_depc(rt_to_depc)
    );

    exc_debug_gate #(.DEBUG_LEVEL(DEBUG_LEVEL)) u_dbg (
        .dbg_valid(dbg_valid), .ps_cur(ps), .take(dbg_take), .ps_dbg(ps_dbg)
    );

    // A general request proceeds only if accepted and not pre-empted by debug.
    assign gen_take = req_valid && cls_accept && !dbg_take;

    // State update: debug entry, general entry, or status load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps        <= RESET_PS;
            epc       <= '0;
            depc      <= '0;
            exccause  <= '0;
            excvaddr  <= '0;
            dbgcause  <= '0;
            dbg_epc   <= '0;
            dbg_eps   <= '0;
            redirect  <= 1'b0;
            vector_id <= VEC_NONE;
        end else begin
            redirect  <= 1'b0;
            vector_id <= VEC_NONE;
            if (dbg_take) begin
                dbgcause  <= dbg_cause;
                dbg_epc   <= dbg_pc;
                dbg_eps   <= ps;
                ps        <= ps_dbg;
                redirect  <= 1'b1;
                vector_id <= VEC_DEBUG;
            end else if (gen_take) begin
                if (rt_to_epc)   epc      <= req_pc;
                if (rt_to_depc)  depc     <= req_pc;
                if (cls_load_va) excvaddr <= cls_va;
                exccause            <= cls_cause;
                ps[PS_EXCM_BIT]     <= 1'b1;
                redirect            <= 1'b1;
                vector_id           <= rt_vec;
            end else if (ps_wr_en) begin
                ps <= ps_wr_data;
            end
        end
    end

    // R4: every redirect leaves exception mode set.
    p_excm_on_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ps[PS_EXCM_BIT]);

    // R3: nested general exception goes to the double vector.
    p_double_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_take && ps[PS_EXCM_BIT]) |=> (vector_id == VEC_DOUBLE));

    // R8: debug vector implies the debug interrupt level.
    p_debug_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_id == VEC_DEBUG) |-> (ps[PS_LVL_LSB +: PS_LVL_W] == PS_LVL_W'(DEBUG_LEVEL)));

    // R9: a refused debug request alone changes nothing.
    p_dbg_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid && !dbg_take && !req_valid && !ps_wr_en) |=> ($stable(ps) && !redirect));

    // R10: debug beats a simultaneous general request.
    p_dbg_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_take && req_valid) |=> ((vector_id == VEC_DEBUG) && $stable(exccause)));

    // R11: no vector without redirect.
    p_vector_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> (vector_id == VEC_NONE));

    // R12: a status load coinciding with an entry is discarded.
    p_psload_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr_en && (dbg_take || gen_take)) |=> ps[PS_EXCM_BIT]);
endmodule

// File: tb/exc_entry_ctrl_test.sv
// Sweeping bench: status flags x request kinds x fetch flag, all interrupt
// levels for debug, and coinciding requests. Expected state from a model
// built on the written requirements.
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DL         = 6;
    localparam bit DEPC_ON    = 1'b1;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv = 1'b0;
    logic [1:0]  kind = '0;
    logic [5:0]  rc = '0;
    logic [31:0] rpc = '0;
    logic [31:0] rva = '0;
    logic        fetch = 1'b0;
    logic        dv = 1'b0;
    logic [5:0]  dc = '0;
    logic [31:0] dpc = '0;
    logic        pl = 1'b0;
    logic [7:0]  pdata = '0;

    logic [7:0]  ps, dbg_eps, na_ps, na_eps;
    logic [31:0] epc, depc, excvaddr, dbg_epc, na_epc, na_depc, na_va, na_depc2;
    logic [5:0]  exccause, dbgcause, na_cause, na_dcause;
    logic        redirect, na_redirect;
    logic [2:0]  vector_id, na_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    logic [7:0]  m_ps, m_eps;
    logic [31:0] m_epc, m_depc, m_va, m_dpc;
    logic [5:0]  m_cause, m_dcause;
    logic        m_redir;
    logic [2:0]  m_vec;

    exc_entry_ctrl #(.HAS_DEPC(DEPC_ON), .DEBUG_LEVEL(DL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_kind(kind), .req_cause(rc),
        .req_pc(rpc), .req_vaddr(rva), .req_is_fetch(fetch), .dbg_valid(dv),
        .dbg_cause(dc), .dbg_pc(dpc), .ps_wr_en(pl), .ps_wr_data(pdata),
        .ps(ps), .epc(epc), .depc(depc), .exccause(exccause), .excvaddr(excvaddr),
        .dbgcause(dbgcause), .dbg_epc(dbg_epc), .dbg_eps(dbg_eps),
        .redirect(redirect), .vector_id(vector_id)
    );

    // Second configuration: misaligned accesses do not trap.
    exc_entry_ctrl #(.UNALIGNED_EXC(1'b0), .DEBUG_LEVEL(DL)) uut_na (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_kind(kind), .req_cause(rc),
        .req_pc(rpc), .req_vaddr(rva), .req_is_fetch(fetch), .dbg_valid(dv),
        .dbg_cause(dc), .dbg_pc(dpc), .ps_wr_en(pl), .ps_wr_data(pdata),
        .ps(na_ps), .epc(na_epc), .depc(na_depc), .exccause(na_cause), .excvaddr(na_va),
        .dbgcause(na_dcause), .dbg_epc(na_depc2), .dbg_eps(na_eps),
        .redirect(na_redirect), .vector_id(na_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: an overrun is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic compare_all(string tag);
        chk(tag, "ps", 32'(ps), 32'(m_ps));
        chk(tag, "epc", epc, m_epc);
        chk(tag, "depc", depc, m_depc);
        chk(tag, "exccause", 32'(exccause), 32'(m_cause));
        chk(tag, "excvaddr", excvaddr, m_va);
        chk(tag, "dbgcause", 32'(dbgcause), 32'(m_dcause));
        chk(tag, "dbg_epc", dbg_epc, m_dpc);
        chk(tag, "dbg_eps", 32'(dbg_eps), 32'(m_eps));
        chk(tag, "redirect", 32'(redirect), 32'(m_redir));
        chk(tag, "vector_id", 32'(vector_id), 32'(m_vec));
    endtask

    // One cycle: model the edge, let it happen, compare at the next falling edge.
    task automatic step(string tag);
        logic dbg_ok, gen_ok;
        logic [5:0] cause;
        logic [5:0] na_cause_before;
        logic na_watch;
        dbg_ok = dv && (m_ps[3:0] < 4'(DL));
        gen_ok = rv && !dbg_ok;
        na_watch = rv && !dv && (kind == 2'd2);
        na_cause_before = na_cause;
        m_redir = 1'b0;
        m_vec = 3'd0;
        if (dbg_ok) begin
            m_dcause = dc;
            m_dpc = dpc;
            m_eps = m_ps;
            m_ps = {m_ps[7:5], 1'b1, 4'(DL)};
            m_redir = 1'b1;
            m_vec = 3'd4;
        end else if (gen_ok) begin
            cause = rc;
            case (kind)
                2'd1: m_va = rva;
                2'd2: begin cause = 6'd9; m_va = rva; end
                2'd3: begin
                    cause = fetch ? 6'd12 : 6'd13;
                    m_va = fetch ? rpc : rva;
                end
                default: ;
            endcase
            if (m_ps[4]) begin
                m_vec = 3'd3;
                if (DEPC_ON) m_depc = rpc; else m_epc = rpc;
            end else begin
                m_epc = rpc;
                m_vec = m_ps[5] ? 3'd2 : 3'd1;
            end
            m_cause = cause;
            m_ps[4] = 1'b1;
            m_redir = 1'b1;
        end else if (pl) begin
            m_ps = pdata;
        end
        @(negedge clk);
        compare_all(tag);
        if (na_watch) begin
            chk("R6", "ignored misalign redirect", 32'(na_redirect), 32'd0);
            chk("R6", "ignored misalign cause", 32'(na_cause), 32'(na_cause_before));
        end
        rv = 1'b0;
        dv = 1'b0;
        pl = 1'b0;
    endtask

    initial begin
        m_ps = 8'h1F; m_eps = '0; m_epc = '0; m_depc = '0; m_va = '0; m_dpc = '0;
        m_cause = '0; m_dcause = '0; m_redir = 1'b0; m_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // General request sweep over mode flags, kinds and fetch flag.
        for (int um = 0; um < 2; um++)
            for (int ex = 0; ex < 2; ex++)
                for (int k = 0; k < 4; k++)
                    for (int f = 0; f < 2; f++) begin
                        pl = 1'b1;
                        pdata = {2'b01, 1'(um), 1'(ex), 4'h3};
                        step("R12");
                        rv = 1'b1;
                        kind = 2'(k);
                        fetch = 1'(f);
                        rc = 6'(k * 7 + um * 3 + ex + f + 1);
                        rpc = 32'h4000_0000 + 32'((um * 16 + ex * 8 + k * 2 + f) * 16);
                        rva = 32'h8000_0100 + 32'((um * 16 + ex * 8 + k * 2 + f) * 4);
                        case (k)
                            0: step("R2/R3/R4");
                            1: step("R5");
                            2: step("R6");
                            default: step("R7");
                        endcase
                        step("R11");
                    end

        // Debug sweep over all interrupt levels.
        for (int lvl = 0; lvl < 16; lvl++) begin
            pl = 1'b1;
            pdata = {2'b10, 1'b1, 1'b0, 4'(lvl)};
            step("R12");
            dv = 1'b1;
            dc = 6'(lvl + 1);
            dpc = 32'hC000_0000 + 32'(lvl * 4);
            if (lvl < DL) step("R8"); else step("R9");
            step("R11");
        end

        // Debug and general request together at every level.
        for (int lvl = 0; lvl < 16; lvl++) begin
            pl = 1'b1;
            pdata = {2'b00, 1'b0, 1'b0, 4'(lvl)};
            step("R12");
            dv = 1'b1;
            dc = 6'(40 + lvl);
            dpc = 32'hD000_0000 + 32'(lvl * 8);
            rv = 1'b1;
            kind = 2'd1;
            rc = 6'(20 + lvl);
            rpc = 32'hE000_0000 + 32'(lvl * 8);
            rva = 32'hF000_0000 + 32'(lvl);
            step("R10");
        end

        // Status load together with a general entry is discarded.
        pl = 1'b1;
        pdata = 8'h00;
        step("R12");
        rv = 1'b1;
        kind = 2'd0;
        rc = 6'd33;
        rpc = 32'h1234_5678;
        pl = 1'b1;
        pdata = 8'hC5;
        step("R12");
        step("R11");

        finish_run();
    end
endmodule